// File: doc/BRIEF.md
# Ordered Power-of-Two Domain Clock Divider

This block holds one 16-bit control word that sets the division ratio of six clock domains fed from a single parent clock. The domains are the CPU, DSP, DSP memory-management unit (MMU), traffic controller (TC), LCD and peripheral bus. Each domain has a 2-bit exponent `e`. The block produces a clock-enable stream for that domain that is high one parent cycle in every `2^e` cycles.

The rates of the domains must keep a fixed order. A write is not stored as written. Before it is stored, the word passes through a combinational clamp that repairs any exponent breaking the order. The repaired word is what is held and what the read port shows. The clamp enforces only the relative order between domains; it does not check any absolute frequency limit.

Each write also restarts every enable generator at the start of its period. As a result, no pulse spaced for the old ratio appears after the change.

Top module: `domain_clock_divider`

## Requirements
- R1: While `rst` is high, and after it falls until the first write, `rd_data` is 0 and every bit of `dom_ce` is high in every cycle (all domains divide by 1).
- R2: A cycle with `wr_en` high stores the clamped form of `wr_data`. `rd_data` shows that stored word from the next cycle on.
- R3: Field layout of the control word, as exponents: CPU [1:0], DSP [3:2], MMU [5:4], TC [7:6], LCD [9:8], peripheral [11:10]. The stored MMU exponent lies between the DSP exponent and the DSP exponent plus one, inclusive. The clamp raises it to the DSP exponent when it is below that, and lowers it to the DSP exponent plus one when it is above that.
- R4: The stored TC exponent is the largest of the written TC exponent, the CPU exponent and the already-clamped MMU exponent.
- R5: The stored LCD exponent and the stored peripheral exponent are each the larger of the written value and the final TC exponent.
- R6: Bits [15:12] are stored exactly as written. The CPU and DSP exponents are never changed by the clamp.
- R7: `dom_ce` bit order is CPU=0, DSP=1, MMU=2, TC=3, LCD=4, peripheral=5. In the first cycle after a write, every `dom_ce` bit is high. After that, bit d is high exactly in cycles k (counted from 0 at the first cycle after the write) for which k mod 2^e = 0, where e is the stored exponent of domain d.
- R8: A written word that already satisfies R3 to R5 is stored unchanged.
- R9: While `wr_en` stays low, `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to be clamped and stored |
| rd_data | output | 16 | Stored (clamped) control word |
| dom_ce | output | 6 | Per-domain clock-enable pulses |

## Verification
The bench writes every one of the 4096 exponent combinations and compares the stored word with an arithmetic model. This catches four kinds of error: a clamp applied in the wrong order (TC computed from the unclamped MMU value), an MMU bound that is off by one, LCD or peripheral compared against the written TC value instead of the final one, and upper bits that get lost. After each write it follows the enable streams for several cycles. Every other write lands mid-period. This exposes a generator that does not restart, which would emit a pulse spaced for the old ratio. It also exposes a mask error that gives the wrong period for a divide-by-8 domain.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  localparam int EXP_W  = 2;
  localparam int N_DOM  = 6;
  localparam int WORD_W = 16;

  // domain slot order inside the control word and the enable vector
  localparam int D_CPU = 0;
  localparam int D_DSP = 1;
  localparam int D_MMU = 2;
  localparam int D_TC  = 3;
  localparam int D_LCD = 4;
  localparam int D_PER = 5;
endpackage

// File: rtl/dcd_clamp.sv
module dcd_clamp
  import dcd_pkg::*;
#(
  parameter int WORD_W_P = WORD_W,
  parameter int EXP_W_P  = EXP_W
) (
  input  logic [WORD_W_P-1:0] raw_word,
  output logic [WORD_W_P-1:0] fixed_word
);
  localparam int WIDE = EXP_W_P + 1;

  logic [WIDE-1:0] cpu_e, dsp_e, mmu_e, tc_e, lcd_e, per_e;

  always_comb begin
    cpu_e = {1'b0, raw_word[D_CPU*EXP_W_P +: EXP_W_P]};
    dsp_e = {1'b0, raw_word[D_DSP*EXP_W_P +: EXP_W_P]};
    mmu_e = {1'b0, raw_word[D_MMU*EXP_W_P +: EXP_W_P]};
    tc_e  = {1'b0, raw_word[D_TC *EXP_W_P +: EXP_W_P]};
    lcd_e = {1'b0, raw_word[D_LCD*EXP_W_P +: EXP_W_P]};
    per_e = {1'b0, raw_word[D_PER*EXP_W_P +: EXP_W_P]};

    // step 1: MMU tracks DSP rate or half of it
    if (mmu_e < dsp_e) mmu_e = dsp_e;
    if (mmu_e > dsp_e + WIDE'(1)) mmu_e = dsp_e + WIDE'(1);
    // step 2: TC never faster than CPU or MMU
    if (tc_e < cpu_e) tc_e = cpu_e;
    if (tc_e < mmu_e) tc_e = mmu_e;
    // step 3: slow domains never faster than TC
    if (lcd_e < tc_e) lcd_e = tc_e;
    if (per_e < tc_e) per_e = tc_e;

    fixed_word = raw_word;
    fixed_word[D_MMU*EXP_W_P +: EXP_W_P] = mmu_e[EXP_W_P-1:0];
    fixed_word[D_TC *EXP_W_P +: EXP_W_P] = tc_e[EXP_W_P-1:0];
    fixed_word[D_LCD*EXP_W_P +: EXP_W_P] = lcd_e[EXP_W_P-1:0];
    fixed_word[D_PER*EXP_W_P +: EXP_W_P] = per_e[EXP_W_P-1:0];
  end
endmodule

// File: rtl/dcd_word_reg.sv
module dcd_word_reg
  import dcd_pkg::*;
#(
  parameter int WORD_W_P = WORD_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [WORD_W_P-1:0] next_word,
  output logic [WORD_W_P-1:0] held_word
);
  always_ff @(posedge clk) begin
    if (rst)       held_word <= '0;
    else if (load) held_word <= next_word;
  end
endmodule

// File: rtl/dcd_ce_gen.sv
module dcd_ce_gen #(
  parameter int EXP_W_P = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic [EXP_W_P-1:0] expo,
  output logic               ce
);
  localparam int CNT_W = (1 << EXP_W_P) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] mask;

  always_comb begin
    span = (CNT_W+1)'(1) << expo;
    mask = CNT_W'(span - (CNT_W+1)'(1));
    ce   = (cnt & mask) == '0;
  end

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else                cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/domain_clock_divider.sv
module domain_clock_divider
  import dcd_pkg::*;
#(
  parameter int WORD_W_P = WORD_W,
  parameter int EXP_W_P  = EXP_W,
  parameter int N_DOM_P  = N_DOM
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [WORD_W_P-1:0] wr_data,
  output logic [WORD_W_P-1:0] rd_data,
  output logic [N_DOM_P-1:0]  dom_ce
);
  logic [WORD_W_P-1:0] clamped;

  dcd_clamp #(.WORD_W_P(WORD_W_P), .EXP_W_P(EXP_W_P)) i_clamp (
    .raw_word  (wr_data),
    .fixed_word(clamped)
  );

  dcd_word_reg #(.WORD_W_P(WORD_W_P)) i_reg (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_en),
    .next_word(clamped),
    .held_word(rd_data)
  );

  for (genvar d = 0; d < N_DOM_P; d++) begin : g_dom
    dcd_ce_gen #(.EXP_W_P(EXP_W_P)) i_gen (
      .clk    (clk),
      .rst    (rst),
      .restart(wr_en),
      .expo   (rd_data[d*EXP_W_P +: EXP_W_P]),
      .ce     (dom_ce[d])
    );
  end
endmodule

// File: rtl/dcd_checker.sv
module dcd_checker
  import dcd_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_data,
  input logic [WORD_W-1:0] rd_data,
  input logic [N_DOM-1:0]  dom_ce
);
  logic [EXP_W:0] cpu_f, dsp_f, mmu_f, tc_f, lcd_f, per_f;
  assign cpu_f = {1'b0, rd_data[D_CPU*EXP_W +: EXP_W]};
  assign dsp_f = {1'b0, rd_data[D_DSP*EXP_W +: EXP_W]};
  assign mmu_f = {1'b0, rd_data[D_MMU*EXP_W +: EXP_W]};
  assign tc_f  = {1'b0, rd_data[D_TC *EXP_W +: EXP_W]};
  assign lcd_f = {1'b0, rd_data[D_LCD*EXP_W +: EXP_W]};
  assign per_f = {1'b0, rd_data[D_PER*EXP_W +: EXP_W]};

  localparam int FLD = N_DOM * EXP_W;

  a_r1_reset_clear: assert property (@(posedge clk) rst |=> rd_data == '0);

  a_r3_mmu_window: assert property (@(posedge clk) disable iff (rst)
    (mmu_f >= dsp_f) && (mmu_f <= dsp_f + 1'b1));

  a_r4_tc_order: assert property (@(posedge clk) disable iff (rst)
    (tc_f >= cpu_f) && (tc_f >= mmu_f));

  a_r5_slow_domains: assert property (@(posedge clk) disable iff (rst)
    (lcd_f >= tc_f) && (per_f >= tc_f));

  a_r6_upper_kept: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data[WORD_W-1:FLD] == $past(wr_data[WORD_W-1:FLD]));

  a_r7_restart_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> &dom_ce);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rd_data));
endmodule

bind domain_clock_divider dcd_checker i_dcd_checker (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en),
  .wr_data(wr_data),
  .rd_data(rd_data),
  .dom_ce (dom_ce)
);

// File: tb/test_domain_clock_divider.sv
`timescale 1ns/1ps
module test_domain_clock_divider;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic [5:0]  dom_ce;

  int errs = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  domain_clock_divider i_domain_clock_divider (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .dom_ce(dom_ce)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] model(input logic [15:0] w);
    int cpu = w[1:0];
    int dsp = w[3:2];
    int mmu = w[5:4];
    int tc  = w[7:6];
    int lcd = w[9:8];
    int per = w[11:10];
    if (mmu < dsp) mmu = dsp;
    if (mmu > dsp + 1) mmu = dsp + 1;
    if (tc < cpu) tc = cpu;
    if (tc < mmu) tc = mmu;
    if (lcd < tc) lcd = tc;
    if (per < tc) per = tc;
    return {w[15:12], 2'(per), 2'(lcd), 2'(tc), 2'(mmu), 2'(dsp), 2'(cpu)};
  endfunction

  initial begin
    #(5.0 * 150000);
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst = 1'b1;
    wr_en = 1'b0;
    wr_data = '0;
    repeat (3) @(negedge clk);
    chk(rd_data == 16'h0, "R1 reset word", int'(rd_data), 0);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(dom_ce == 6'h3f, "R1 divide-by-1 after reset", int'(dom_ce), 'h3f);
    end

    for (int i = 0; i < 4096; i++) begin
      logic [15:0] w, exp_w;
      int ncyc;
      w = {4'((i * 5) + (i >> 6)), 12'(i)};
      exp_w = model(w);
      ncyc = (i % 2 == 1) ? 5 : 8;
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = w;
      @(negedge clk);
      wr_en = 1'b0;
      wr_data = ~w;
      if (exp_w == w)
        chk(rd_data == exp_w, "R8 legal word unchanged", int'(rd_data), int'(exp_w));
      else
        chk(rd_data == exp_w, "R2 clamped word stored", int'(rd_data), int'(exp_w));
      chk(rd_data[5:4] >= rd_data[3:2] && int'(rd_data[5:4]) <= int'(rd_data[3:2]) + 1,
          "R3 mmu window", int'(rd_data[5:4]), int'(exp_w[5:4]));
      chk(rd_data[7:6] == exp_w[7:6], "R4 tc exponent", int'(rd_data[7:6]), int'(exp_w[7:6]));
      chk(rd_data[11:8] == exp_w[11:8], "R5 lcd/per exponents", int'(rd_data[11:8]), int'(exp_w[11:8]));
      chk(rd_data[15:12] == w[15:12] && rd_data[3:0] == w[3:0],
          "R6 untouched bits", int'(rd_data), int'(w));
      for (int k = 0; k < ncyc; k++) begin
        logic [5:0] exp_ce;
        if (k > 0) @(negedge clk);
        for (int d = 0; d < 6; d++) begin
          int e;
          e = exp_w[d*2 +: 2];
          exp_ce[d] = (k % (1 << e)) == 0;
        end
        chk(dom_ce == exp_ce, "R7 enable pattern", int'(dom_ce), int'(exp_ce));
      end
      chk(rd_data == exp_w, "R9 word held without write", int'(rd_data), int'(exp_w));
    end

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule